// File: doc/BRIEF.md
# Phase-Staggered Multi-Channel PWM Engine

This block drives a bank of pulse-width outputs from one shared free-running counter. Each channel holds its own rising compare point and falling compare point. A channel goes high when the counter reaches its rising point and goes low when the counter reaches its falling point. The counter length is a power of two, so each channel's high window is measured modulo that length. A falling point below the rising point therefore makes a window that wraps through zero. This lets channels with the same duty be spread in phase, so that their edges do not all fall together.

Each channel also has a force-high flag and a force-low flag. Force-low overrides everything. Two controls act on all channels at once: a polarity inversion and a drive mode, which is either push-pull or open-drain. An external tick advances the counter, so the prescaler stays outside the block. New per-channel settings are taken into internal shadow registers only when the counter wraps. A period that is already running is never altered.

Top module: `pwm_phase_engine`

## Requirements
- R1: A 12-bit counter starts at 0 after reset and advances by one on each clock where `tick_i` is high. It goes from 4095 back to 0 and holds its value while `tick_i` is low. The outputs registered on each clock edge reflect the counter value and shadow settings present just before that edge.
- R2: Channel n uses bits [12n+11:12n] of `on_cnt_i` and `off_cnt_i`. With no force flag set, the channel's level is high exactly when (count − on) mod 4096 < (off − on) mod 4096. The level therefore rises at count == on and falls at count == off.
- R3: When off < on, the high window wraps through count 0, and the duty stays (off − on) mod 4096.
- R4: When on == off and no force flag is set, the level stays low for the whole period.
- R5: When a channel's force-low flag is set, its level is low regardless of its force-high flag and its compare values.
- R6: When force-high is set and force-low is clear, the level is high for every count of the period.
- R7: Compare values and force flags are captured only on the tick that moves the counter from 4095 to 0. Changes made at any other time have no effect until the following period.
- R8: When `invert_i` is high, every channel's level is inverted. This control is not shadowed and takes effect at the next clock edge.
- R9: In push-pull mode (`open_drain_i` low), `pwm_o[n]` carries the level and `pwm_oe_o[n]` is 1.
- R10: In open-drain mode (`open_drain_i` high), `pwm_o[n]` is 0 and `pwm_oe_o[n]` is the inverse of the level. A high level is therefore a released pin, and a low level is a driven 0.
- R11: While `rst` is high, `pwm_o` and `pwm_oe_o` are all 0. After reset, every shadow register holds force-low, so every level is low until the first wrap loads real settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Counter advance strobe |
| on_cnt_i | input | 192 | Rising compare point per channel, 12 bits each |
| off_cnt_i | input | 192 | Falling compare point per channel, 12 bits each |
| force_on_i | input | 16 | Per-channel force-high flags |
| force_off_i | input | 16 | Per-channel force-low flags, which take precedence |
| invert_i | input | 1 | Global polarity inversion |
| open_drain_i | input | 1 | Global drive mode: 1 selects open-drain, 0 selects push-pull |
| pwm_o | output | 16 | Registered pin data per channel |
| pwm_oe_o | output | 16 | Registered pin drive enable per channel |

## Verification
A corrupted shadow register cannot appear mid-period. It shows at the first count after the next wrap, where the channel's edge lands at the wrong count or disappears, so the bench compares all sixteen pins at counts placed on and beside each rising and falling point. A counter that skips or fails to hold moves every edge on every channel at once. The tick-pause check catches this within one clock. An error in the inversion or drive-mode stage shows on the first edge after that control changes, and the bench samples exactly that cycle on both sides of each change.

// File: rtl/pwm_eng_pkg.sv
package pwm_eng_pkg;

  localparam int unsigned CNT_W_DEF  = 12;
  localparam int unsigned NUM_CH_DEF = 16;

  typedef enum logic {
    DRV_PUSHPULL  = 1'b0,
    DRV_OPENDRAIN = 1'b1
  } drive_mode_e;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == CNT_MAX);

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt_q == CNT_MAX) |=> (cnt_q == '0));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_chan_slot.sv
module pwm_chan_slot #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] rise_i,
  input  logic [CNT_W-1:0] fall_i,
  input  logic             hold_hi_i,
  input  logic             hold_lo_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             level_o
);

  logic [CNT_W-1:0] rise_q;
  logic [CNT_W-1:0] fall_q;
  logic             hold_hi_q;
  logic             hold_lo_q;
  logic [CNT_W-1:0] since_rise;
  logic [CNT_W-1:0] span;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q    <= '0;
      fall_q    <= '0;
      hold_hi_q <= 1'b0;
      hold_lo_q <= 1'b1;
    end else if (load_i) begin
      rise_q    <= rise_i;
      fall_q    <= fall_i;
      hold_hi_q <= hold_hi_i;
      hold_lo_q <= hold_lo_i;
    end
  end

  // Modular distances: the high window is [rise, rise+span) on the ring.
  assign since_rise = cnt_i - rise_q;
  assign span       = fall_q - rise_q;

  always_comb begin
    if (hold_lo_q) begin
      level_o = 1'b0;
    end else if (hold_hi_q) begin
      level_o = 1'b1;
    end else begin
      level_o = (since_rise < span);
    end
  end

  // R5
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && hold_lo_i) |=> !level_o);

  // R6
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && hold_hi_i && !hold_lo_i) |=> level_o);

  // R4
  equal_points_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && rise_i == fall_i && !hold_hi_i && !hold_lo_i) |=> !level_o);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(rise_q) && $stable(fall_q) && $stable(hold_hi_q) && $stable(hold_lo_q)));

endmodule

// File: rtl/pwm_pin_drive.sv
module pwm_pin_drive
  import pwm_eng_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] level_i,
  input  logic              invert_i,
  input  drive_mode_e       mode_i,
  output logic [NUM_CH-1:0] pin_o,
  output logic [NUM_CH-1:0] oe_o
);

  logic [NUM_CH-1:0] polar;
  logic [NUM_CH-1:0] pin_d;
  logic [NUM_CH-1:0] oe_d;

  assign polar = level_i ^ {NUM_CH{invert_i}};

  always_comb begin
    if (mode_i == DRV_OPENDRAIN) begin
      pin_d = '0;
      oe_d  = ~polar;
    end else begin
      pin_d = polar;
      oe_d  = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o <= '0;
      oe_o  <= '0;
    end else begin
      pin_o <= pin_d;
      oe_o  <= oe_d;
    end
  end

  // R10
  od_data_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == DRV_OPENDRAIN) |=> (pin_o == '0));

  // R9
  pp_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == DRV_PUSHPULL) |=> (oe_o == '1));

  // R9
  pp_data_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == DRV_PUSHPULL && !invert_i) |=> (pin_o == $past(level_i)));

endmodule

// File: rtl/pwm_phase_engine.sv
module pwm_phase_engine
  import pwm_eng_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned CNT_W  = CNT_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_i,
  input  logic [NUM_CH*CNT_W-1:0]   on_cnt_i,
  input  logic [NUM_CH*CNT_W-1:0]   off_cnt_i,
  input  logic [NUM_CH-1:0]         force_on_i,
  input  logic [NUM_CH-1:0]         force_off_i,
  input  logic                      invert_i,
  input  logic                      open_drain_i,
  output logic [NUM_CH-1:0]         pwm_o,
  output logic [NUM_CH-1:0]         pwm_oe_o
);

  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [NUM_CH-1:0] level;
  drive_mode_e       mode;

  pwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
    pwm_chan_slot #(.CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .load_i    (wrap),
      .rise_i    (on_cnt_i[ch*CNT_W +: CNT_W]),
      .fall_i    (off_cnt_i[ch*CNT_W +: CNT_W]),
      .hold_hi_i (force_on_i[ch]),
      .hold_lo_i (force_off_i[ch]),
      .cnt_i     (cnt),
      .level_o   (level[ch])
    );
  end

  assign mode = open_drain_i ? DRV_OPENDRAIN : DRV_PUSHPULL;

  pwm_pin_drive #(.NUM_CH(NUM_CH)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .level_i  (level),
    .invert_i (invert_i),
    .mode_i   (mode),
    .pin_o    (pwm_o),
    .oe_o     (pwm_oe_o)
  );

endmodule

// File: tb/tb_pwm_phase_engine.sv
module tb_pwm_phase_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 16;
  localparam int CW   = 12;
  localparam int PLEN = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic inv = 1'b0;
  logic od = 1'b0;
  logic [NCH*CW-1:0] on_flat, off_flat;
  logic [NCH-1:0] fon_v, foff_v;
  logic [NCH-1:0] pwm, oe;

  logic [CW-1:0] on_v [NCH];
  logic [CW-1:0] off_v [NCH];
  logic [CW-1:0] act_on [NCH];
  logic [CW-1:0] act_off [NCH];
  logic [NCH-1:0] act_fon, act_foff;

  int ecount = 0;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int edge_n;
    logic [NCH-1:0] pwm;
    logic [NCH-1:0] oe;
    string tag;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      on_flat[i*CW +: CW]  = on_v[i];
      off_flat[i*CW +: CW] = off_v[i];
    end
  end

  pwm_phase_engine dut (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick),
    .on_cnt_i     (on_flat),
    .off_cnt_i    (off_flat),
    .force_on_i   (fon_v),
    .force_off_i  (foff_v),
    .invert_i     (inv),
    .open_drain_i (od),
    .pwm_o        (pwm),
    .pwm_oe_o     (oe)
  );

  always @(posedge clk) if (!rst) ecount <= ecount + 1;

  // Level per requirements R2..R6 using the settings active in the period.
  function automatic logic lvl(int ch, int c);
    int d, s;
    if (act_foff[ch]) return 1'b0;
    if (act_fon[ch]) return 1'b1;
    d = (c - int'(act_on[ch])) & (PLEN-1);
    s = (int'(act_off[ch]) - int'(act_on[ch])) & (PLEN-1);
    return d < s;
  endfunction

  task automatic push_at(int e, int c, logic iv, logic odm, string tag);
    item_t it;
    logic l;
    it.edge_n = e;
    it.tag = tag;
    for (int ch = 0; ch < NCH; ch++) begin
      l = lvl(ch, c) ^ iv;
      it.pwm[ch] = odm ? 1'b0 : l;
      it.oe[ch]  = odm ? ~l : 1'b1;
    end
    q.push_back(it);
  endtask

  task automatic chk(int p, int c, logic iv, logic odm, string tag);
    push_at(p*PLEN + c + 1, c, iv, odm, tag);
  endtask

  task automatic wait_edge(int n);
    while (ecount < n) @(negedge clk);
  endtask

  task automatic latch_active();
    for (int i = 0; i < NCH; i++) begin
      act_on[i]  = on_v[i];
      act_off[i] = off_v[i];
    end
    act_fon  = fon_v;
    act_foff = foff_v;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    item_t it;
    if (!rst) begin
      while (q.size() > 0 && q[0].edge_n <= ecount) begin
        it = q.pop_front();
        n_chk++;
        if (it.edge_n != ecount || pwm !== it.pwm || oe !== it.oe) begin
          n_fail++;
          $display("FAIL %s edge %0d (at %0d): pwm=%h oe=%h expected pwm=%h oe=%h",
                   it.tag, it.edge_n, ecount, pwm, oe, it.pwm, it.oe);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, queue=%0d expected empty", q.size());
    finish_run();
  end

  initial begin
    // Config A: staggered channels with wraps, equal points and forces.
    for (int i = 0; i < NCH; i++) begin
      on_v[i]  = CW'(i*256);
      off_v[i] = CW'((i*256 + 300 + i*40) % PLEN);
    end
    fon_v = '0;
    foff_v = '0;
    on_v[3] = 12'd1000; off_v[3] = 12'd1000;   // R4
    fon_v[5] = 1'b1;                            // R6
    fon_v[6] = 1'b1; foff_v[6] = 1'b1;          // R5
    foff_v[7] = 1'b1;                           // R5
    // Reset-default shadow is force-low everywhere (R11).
    for (int i = 0; i < NCH; i++) begin act_on[i] = '0; act_off[i] = '0; end
    act_fon = '0;
    act_foff = '1;

    // R11: outputs during reset
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (pwm !== '0 || oe !== '0) begin
        n_fail++;
        $display("FAIL R11 in reset: pwm=%h oe=%h expected pwm=0000 oe=0000", pwm, oe);
      end
    end
    chk(0, 0,    1'b0, 1'b0, "R11 default shadow c0");
    chk(0, 1000, 1'b0, 1'b0, "R11 default shadow c1000");
    chk(0, 4095, 1'b0, 1'b0, "R11 default shadow c4095");
    rst = 1'b0;

    // Period 1: config A active.
    wait_edge(PLEN);
    latch_active();
    chk(1, 0,    0, 0, "R2 R3 c0");
    chk(1, 255,  0, 0, "R2 c255");
    chk(1, 256,  0, 0, "R2 rise c256");
    chk(1, 300,  0, 0, "R2 c300");
    chk(1, 347,  0, 0, "R3 c347");
    chk(1, 348,  0, 0, "R3 fall c348");
    chk(1, 595,  0, 0, "R2 c595");
    chk(1, 596,  0, 0, "R2 fall c596");
    chk(1, 643,  0, 0, "R3 c643");
    chk(1, 644,  0, 0, "R3 fall c644");
    chk(1, 1000, 0, 0, "R4 R5 R6 c1000");
    chk(1, 1001, 0, 0, "R4 c1001");
    chk(1, 1999, 0, 0, "R2 c1999");
    chk(1, 3000, 0, 0, "R7 old settings c3000");
    chk(1, 3839, 0, 0, "R7 R3 c3839");
    chk(1, 3840, 0, 0, "R7 R3 rise c3840");
    chk(1, 4095, 0, 0, "R7 c4095");
    wait_edge(PLEN + 2001);
    // Config B, written mid-period: must wait for the wrap (R7).
    for (int i = 0; i < NCH; i++) begin
      on_v[i]  = CW'(4095 - i*200);
      off_v[i] = CW'((4095 - i*200 + 2048) % PLEN);
    end
    on_v[0] = 12'd0; off_v[0] = 12'd4095;
    fon_v = '0;
    foff_v = '0;

    // Period 2: config B, push-pull, inversion switched on at c1500.
    wait_edge(2*PLEN);
    latch_active();
    chk(2, 0,    0, 0, "R7 R9 c0");
    chk(2, 1095, 0, 0, "R9 R3 c1095");
    chk(2, 1499, 0, 0, "R8 before c1499");
    chk(2, 1500, 1, 0, "R8 after c1500");
    chk(2, 2047, 1, 0, "R8 c2047");
    chk(2, 3143, 1, 0, "R8 c3143");
    chk(2, 4094, 1, 0, "R8 c4094");
    chk(2, 4095, 1, 0, "R8 c4095");
    wait_edge(2*PLEN + 1500);
    inv = 1'b1;

    // Period 3: open-drain, inversion off then on.
    wait_edge(3*PLEN);
    inv = 1'b0;
    od = 1'b1;
    chk(3, 0,    0, 1, "R10 c0");
    chk(3, 1095, 0, 1, "R10 c1095");
    chk(3, 2000, 0, 1, "R10 c2000");
    chk(3, 2001, 1, 1, "R10 R8 c2001");
    chk(3, 4095, 1, 1, "R10 R8 c4095");
    wait_edge(3*PLEN + 2001);
    inv = 1'b1;

    // Period 4: counter pause with tick low.
    wait_edge(4*PLEN);
    latch_active();
    chk(4, 5, 1, 1, "R1 c5");
    push_at(4*PLEN + 10, 9, 1, 1, "R1 c9");
    for (int k = 1; k <= 4; k++) push_at(4*PLEN + 10 + k, 10, 1, 1, "R1 hold c10");
    wait_edge(4*PLEN + 10);
    tick = 1'b0;
    wait_edge(4*PLEN + 16);
    if (q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 leftover items: %0d expected 0", q.size());
    end
    finish_run();
  end

endmodule